// File: doc/BRIEF.md
# Cache Line Write Backup Queue

This block keeps an ordered record of the address/data pairs written by allocate-and-store operations aimed at cacheable memory. If a cache line is later invalidated before its data has reached memory, the saved words for that line can be recovered and written out as ordinary memory stores. A push is recorded only when its cacheable flag is set. An invalidate request searches the queue by 32-byte line, starting from the oldest entry. The first entry that matches is replayed as a store and then removed from the middle of the queue.

Removal closes the gap: the entries behind the removed one move one place toward the head in the cycle the store handshake completes, so arrival order is kept. A discard command drops every entry at once. While a store is outstanding the block raises `busy`, and it ignores push, invalidate and discard requests until the handshake completes. The queue depth is a parameter. A cacheable push into a full queue is dropped and sets a sticky overflow flag.

Top module: `line_backup_queue`

## Requirements
- R1: After reset the queue is empty, `st_valid`, `busy` and `overflow` are 0, and every invalidate misses.
- R2: A push with `push_cacheable`=1 and `busy`=0 is recorded. A push with `push_cacheable`=0 changes nothing.
- R3: Entries are kept in arrival order, and each new entry is appended behind all the entries already held.
- R4: An invalidate matches an entry when address bits [31:5] are equal. Bits [4:0] are ignored in the comparison, so two addresses in the same 32-byte line match.
- R5: The search starts at the oldest entry. Only the first matching entry is replayed and removed; other entries of the same line stay in the queue.
- R6: On a hit, `st_valid` rises in the cycle after the request. `st_addr` and `st_data` carry the entry's saved address and data, not the request address, and they stay stable until `st_ready` is 1.
- R7: The entry is removed on the clock edge where `st_valid` and `st_ready` are both 1. `st_valid` is 0 in the following cycle, and the later entries keep their relative order.
- R8: An invalidate that matches no entry issues no store and leaves the queue unchanged.
- R9: With `busy`=0, `discard` empties the whole queue. It takes priority over a push or an invalidate presented in the same cycle.
- R10: A cacheable push into a queue holding DEPTH entries is dropped and sets `overflow`. `overflow` stays set until reset, including across a discard.
- R11: `busy` is 1 while a store is pending. Push, invalidate and discard requests presented while `busy`=1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_addr | input | 32 | Address of the allocate-and-store |
| push_data | input | 32 | Data word of the allocate-and-store |
| push_cacheable | input | 1 | Target is cacheable; a push is recorded only when this is 1 |
| inv_valid | input | 1 | Invalidate request |
| inv_addr | input | 32 | Address of the line being invalidated |
| discard | input | 1 | Drop all entries |
| busy | output | 1 | Store pending; requests are ignored |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request accepted |
| st_addr | output | 32 | Saved address to store |
| st_data | output | 32 | Saved data to store |
| overflow | output | 1 | Sticky: a push was dropped because the queue was full |

## Verification
A wrong pointer, count or shift inside the queue shows up at the ports as a store with the wrong address or data. It can also appear as a hit where a miss is expected, or as a miss where a hit is expected. This happens on the next invalidate that reaches the damaged entry, so the bench drains the queue line by line and compares each replay against a reference queue. A compaction error is visible one cycle after the handshake, when the following invalidate replays entries out of their arrival order. A failure to hold the store request shows up as a change of `st_addr` or `st_data` during the stall cycles, which the bench samples each cycle while `st_ready` is held low.

// File: rtl/line_backup_queue.sv
module line_backup_queue #(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          push_cacheable,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  input  logic          discard,
  output logic          busy,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          overflow
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [CW-1:0] cnt;
  logic          pend;
  logic [IW-1:0] pidx;
  logic          ovf;

  logic          hit;
  logic [IW-1:0] hit_idx;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CW'(i) < cnt && addr_q[i][AW-1:LINE_BITS] == inv_addr[AW-1:LINE_BITS]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  wire idle     = !pend;
  wire full     = (cnt == CW'(DEPTH));
  wire take_req = idle & !discard;
  wire do_push  = take_req & push_valid & push_cacheable;
  wire do_inv   = take_req & inv_valid & hit;
  wire done     = pend & st_ready;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (done && IW'(g) >= pidx) begin
          addr_q[g] <= addr_q[g+1];
          data_q[g] <= data_q[g+1];
        end else if (do_push && !full && CW'(g) == cnt) begin
          addr_q[g] <= push_addr;
          data_q[g] <= push_data;
        end
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (do_push && !full && CW'(g) == cnt) begin
          addr_q[g] <= push_addr;
          data_q[g] <= push_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
      pidx <= '0;
      ovf  <= 1'b0;
    end else if (done) begin
      pend <= 1'b0;
      cnt  <= cnt - 1'b1;
    end else if (idle && discard) begin
      cnt <= '0;
    end else begin
      if (do_inv) begin
        pend <= 1'b1;
        pidx <= hit_idx;
      end
      if (do_push) begin
        if (full) ovf <= 1'b1;
        else      cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy     = pend;
  assign st_valid = pend;
  assign st_addr  = addr_q[pidx];
  assign st_data  = data_q[pidx];
  assign overflow = ovf;

  // R6
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(st_data));

  // R7
  store_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |=> !st_valid);

  // R9
  discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && discard |=> cnt == '0 && !st_valid);

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !discard && inv_valid && !hit |=> !st_valid);

  // R2
  uncached_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !discard && !inv_valid && push_valid && !push_cacheable |=> $stable(cnt));
endmodule

// File: tb/line_backup_queue_tb.sv
`timescale 1ns/1ps
module line_backup_queue_tb;
  localparam int D = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        push_valid = 0, push_cacheable = 0, inv_valid = 0, discard = 0, st_ready = 0;
  logic [31:0] push_addr = 0, push_data = 0, inv_addr = 0;
  logic        busy, st_valid, overflow;
  logic [31:0] st_addr, st_data;

  always #2.5 clk = ~clk;

  line_backup_queue #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data),
    .push_cacheable(push_cacheable),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .discard(discard),
    .busy(busy), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .overflow(overflow)
  );

  int checks = 0, fails = 0;
  logic [31:0] m_a [D];
  logic [31:0] m_d [D];
  int m_cnt = 0;
  logic m_ovf = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [31:0] a);
    for (int i = 0; i < m_cnt; i++)
      if (m_a[i][31:5] == a[31:5]) return i;
    return -1;
  endfunction

  function automatic void m_remove(input int k);
    for (int i = k; i < m_cnt - 1; i++) begin
      m_a[i] = m_a[i+1];
      m_d[i] = m_d[i+1];
    end
    m_cnt--;
  endfunction

  function automatic void m_push(input logic [31:0] a, input logic [31:0] d, input logic c);
    if (!c) return;
    if (m_cnt == D) m_ovf = 1;
    else begin
      m_a[m_cnt] = a;
      m_d[m_cnt] = d;
      m_cnt++;
    end
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic t_push(input logic [31:0] a, input logic [31:0] d, input logic c);
    push_valid = 1; push_addr = a; push_data = d; push_cacheable = c;
    tick();
    push_valid = 0;
    m_push(a, d, c);
    chk(overflow == m_ovf, "R10 overflow flag", {31'd0, overflow}, {31'd0, m_ovf});
  endtask

  task automatic t_inv(input logic [31:0] a, input int stall, input string tag);
    int k;
    k = m_find(a);
    inv_valid = 1; inv_addr = a;
    tick();
    inv_valid = 0;
    if (k < 0) begin
      chk(st_valid == 0, {tag, " R8 miss no store"}, {31'd0, st_valid}, 32'd0);
    end else begin
      chk(st_valid == 1 && busy == 1, {tag, " R6 store raised"}, {30'd0, busy, st_valid}, 32'd3);
      chk(st_addr == m_a[k], {tag, " R6 saved address"}, st_addr, m_a[k]);
      chk(st_data == m_d[k], {tag, " R6 saved data"}, st_data, m_d[k]);
      for (int s = 0; s < stall; s++) begin
        tick();
        chk(st_valid && st_addr == m_a[k] && st_data == m_d[k], {tag, " R6 held while stalled"}, st_addr, m_a[k]);
      end
      st_ready = 1;
      tick();
      st_ready = 0;
      chk(st_valid == 0 && busy == 0, {tag, " R7 retired"}, {30'd0, busy, st_valid}, 32'd0);
      m_remove(k);
    end
  endtask

  task automatic t_discard;
    discard = 1;
    tick();
    discard = 0;
    m_cnt = 0;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1
    chk(st_valid == 0 && busy == 0 && overflow == 0, "R1 reset state",
        {29'd0, overflow, busy, st_valid}, 32'd0);
    t_inv(32'h0000_0100, 0, "R1 empty");

    // R2 R3 R4 R5
    t_push(32'h0000_0100, 32'hAAAA_0001, 1);
    t_push(32'h0000_0204, 32'hBBBB_0002, 1);
    t_push(32'h0000_0108, 32'hCCCC_0003, 1);
    t_push(32'h0000_0300, 32'hDDDD_0004, 0);
    t_inv(32'h0000_031C, 0, "R2 uncached");
    chk(st_valid == 0, "R2 uncached push not stored", {31'd0, st_valid}, 32'd0);
    t_inv(32'h0000_011F, 2, "R4 R5 oldest in line");
    t_inv(32'h0000_0100, 1, "R3 R7 next in line");

    // R11: requests while busy are ignored
    t_push(32'h0000_0404, 32'hEEEE_0005, 1);
    inv_valid = 1; inv_addr = 32'h0000_0200;
    tick();
    inv_valid = 0;
    chk(st_addr == 32'h0000_0204, "R11 pending addr", st_addr, 32'h0000_0204);
    push_valid = 1; push_addr = 32'h0000_0500; push_data = 32'h1234_5678; push_cacheable = 1;
    discard = 1; inv_valid = 1; inv_addr = 32'h0000_0404;
    tick();
    push_valid = 0; discard = 0; inv_valid = 0;
    chk(busy && st_addr == 32'h0000_0204, "R11 busy holds request", st_addr, 32'h0000_0204);
    st_ready = 1;
    tick();
    st_ready = 0;
    chk(!busy, "R11 busy released", {31'd0, busy}, 32'd0);
    m_remove(m_find(32'h0000_0200));
    t_inv(32'h0000_0500, 0, "R11 push ignored");
    t_inv(32'h0000_0404, 0, "R11 discard ignored");

    // R9
    t_push(32'h0000_0600, 32'h6, 1);
    t_push(32'h0000_0700, 32'h7, 1);
    discard = 1; push_valid = 1; push_addr = 32'h0000_0800; push_data = 32'h8; push_cacheable = 1;
    tick();
    discard = 0; push_valid = 0;
    m_cnt = 0;
    t_inv(32'h0000_0600, 0, "R9 discard");
    t_inv(32'h0000_0700, 0, "R9 discard");
    t_inv(32'h0000_0800, 0, "R9 discard over push");

    // R10
    for (int i = 0; i <= D; i++) t_push(32'h0000_1000 + i * 32, 32'hF000_0000 + i, 1);
    chk(overflow == 1, "R10 overflow set", {31'd0, overflow}, 32'd1);
    for (int i = 0; i <= D; i++) t_inv(32'h0000_1000 + i * 32 + 4, 0, "R10 drain");
    t_discard();
    chk(overflow == 1, "R10 overflow sticky", {31'd0, overflow}, 32'd1);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] a;
      op = $urandom_range(0, 19);
      a = 32'h0000_2000 + ($urandom_range(0, 5) * 32) + $urandom_range(0, 31);
      if (op < 10) t_push(a, $urandom(), ($urandom_range(0, 3) != 0));
      else if (op < 19) t_inv(a, $urandom_range(0, 3), "R5 random");
      else t_discard();
    end
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < D; j++) t_inv(32'h0000_2000 + i * 32, 0, "R3 random drain");
    chk(m_cnt == 0, "R3 model drained", m_cnt, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule